// File: doc/BRIEF.md
# Quadrature Velocity Period Capture

This block measures how fast an encoder shaft turns by timing how long a fixed number of encoder edges takes. It receives the two phase signals of a quadrature encoder, brings them into the clock domain, and turns their edges into velocity events. In the two-times decoding mode an event comes from every transition of phase A. In the four-times decoding mode an event comes from every transition of either phase. A postscaler passes on one event out of every 1, 4, 16 or 64.

A 16-bit timer advances once per clock. Each postscaler output copies the timer into the period register, raises a one-clock valid strobe and clears the timer, so the captured value is the length of the last group of events. A slow shaft gives a large period value. At high speed, a larger division ratio keeps the period values large enough to resolve. If no capture comes before the timer reaches its maximum, the timer stops there and a sticky overflow flag is raised.

Top module: `qvc_period_capture`

## Requirements
- R1: While reset is applied and just after it, `period_out` is 0, `period_valid` is 0 and `tmr_ovf` is 0.
- R2: When `vel_disable` is 0 and `qmode` is 3'b001 or 3'b010, every rising or falling transition of phase A is one velocity event. Transitions of phase B cause nothing.
- R3: When `vel_disable` is 0 and `qmode` is 3'b101 or 3'b110, every transition of phase A or phase B is one velocity event. If both phases change in the same synchronised sample, that counts as a single event.
- R4: Every other `qmode` code, and `vel_disable` = 1, produce no events and no captures, and they hold the postscaler count at zero.
- R5: `post_sel` values 0, 1, 2 and 3 produce one capture per 1, 4, 16 and 64 events respectively.
- R6: Any change of `vel_disable`, `qmode` or `post_sel` clears the postscaler count, so the next capture needs a full group of events after the change.
- R7: A capture loads the timer value into `period_out` and restarts the timer at 0. The captured value is therefore the number of clock cycles between two consecutive captures minus one.
- R8: `period_valid` is high for exactly one clock per capture. It rises on the fourth rising clock edge after the phase input change that completes the group.
- R9: The timer stops at 0xFFFF. On the clock edge after the timer reaches 0xFFFF without a capture, `tmr_ovf` is set and stays set. The next capture clears it and loads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the timer clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| vel_disable | input | 1 | 1 turns velocity measurement off |
| qmode | input | 3 | Decoding mode code |
| post_sel | input | 2 | Postscaler ratio select (1, 4, 16, 64) |
| period_out | output | 16 | Last captured timer value |
| period_valid | output | 1 | One-clock strobe on each capture |
| tmr_ovf | output | 1 | Sticky timer saturation flag |

## Verification
The capture strobe and the new period value appear on the fourth rising edge after the phase input change that completes a group: two synchroniser flops, the event register, and then the capture register. The overflow flag follows one edge after the timer reaches its maximum. The bench derives each expected period from the stimulus cycles of two completing edges. Because every capture has the same four-edge latency, the latency cancels out of that difference. The bench measures the latency once on its own, and it samples every output on the falling clock edge. The overflow flag is checked long after the saturation point and again after the capture that clears it.

// File: rtl/qvc_pkg.sv
package qvc_pkg;

  typedef enum logic [1:0] {
    EVT_OFF = 2'd0,
    EVT_X2  = 2'd1,
    EVT_X4  = 2'd2
  } evt_mode_e;

  // Maps the mode code and the disable bit to an event decoding variant
  function automatic evt_mode_e decode_mode(input logic [2:0] code, input logic off);
    evt_mode_e m;
    m = EVT_OFF;
    if (!off) begin
      case (code)
        3'b001, 3'b010: m = EVT_X2;
        3'b101, 3'b110: m = EVT_X4;
        default:        m = EVT_OFF;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/qvc_edge_sync.sv
module qvc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic edge_o
);
  // STAGES synchroniser flops followed by one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], raw};
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/qvc_event_gen.sv
module qvc_event_gen
  import qvc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      edge_a,
  input  logic      edge_b,
  input  evt_mode_e mode,
  output logic      evt_q
);
  logic evt_d;

  always_comb begin
    unique case (mode)
      EVT_X2:  evt_d = edge_a;
      EVT_X4:  evt_d = edge_a | edge_b;   // coincident edges give one event
      default: evt_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= evt_d;
  end
endmodule

// File: rtl/qvc_postscaler.sv
module qvc_postscaler #(
  parameter int SEL_W = 2,
  parameter int CFG_W = 6,
  localparam int CNT_W = 2 * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             en,
  input  logic [CFG_W-1:0] cfg,
  input  logic [SEL_W-1:0] sel,
  output logic             fire,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic             cfg_same;

  // Ratio is 4**sel; the terminal count is one below it
  assign span     = (CNT_W+1)'(1) << (2 * sel);
  assign lim_o    = CNT_W'(span - 1'b1);
  assign cfg_same = (cfg == cfg_q);
  assign fire     = evt && en && cfg_same && (cnt_q == lim_o);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg;
      if (!en || !cfg_same)  cnt_q <= '0;
      else if (fire)         cnt_q <= '0;
      else if (evt)          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/qvc_period_capture.sv
module qvc_period_capture
  import qvc_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             vel_disable,
  input  logic [2:0]       qmode,
  input  logic [SEL_W-1:0] post_sel,
  output logic [TMR_W-1:0] period_out,
  output logic             period_valid,
  output logic             tmr_ovf
);
  localparam int CFG_W = 1 + 3 + SEL_W;
  localparam int CNT_W = 2 * ((1 << SEL_W) - 1);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [1:0]       raw_ph;
  logic [1:0]       ph_edge;
  evt_mode_e        mode_w;
  logic             evt_q;
  logic             cap_fire;
  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] div_lim;
  logic [TMR_W-1:0] tmr_q;

  assign raw_ph = {phase_b, phase_a};
  assign mode_w = decode_mode(qmode, vel_disable);

  for (genvar g = 0; g < 2; g++) begin : g_phase
    qvc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .raw    (raw_ph[g]),
      .edge_o (ph_edge[g])
    );
  end

  qvc_event_gen u_evt (
    .clk    (clk),
    .rst    (rst),
    .edge_a (ph_edge[0]),
    .edge_b (ph_edge[1]),
    .mode   (mode_w),
    .evt_q  (evt_q)
  );

  qvc_postscaler #(.SEL_W(SEL_W), .CFG_W(CFG_W)) u_ps (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt_q),
    .en    (mode_w != EVT_OFF),
    .cfg   ({vel_disable, qmode, post_sel}),
    .sel   (post_sel),
    .fire  (cap_fire),
    .cnt_o (div_cnt),
    .lim_o (div_lim)
  );

  // Free-running, saturating period timer; a capture restarts it at zero
  always_ff @(posedge clk) begin
    if (rst)                  tmr_q <= '0;
    else if (cap_fire)        tmr_q <= '0;
    else if (tmr_q != TMR_MAX) tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_out   <= '0;
      period_valid <= 1'b0;
      tmr_ovf      <= 1'b0;
    end else begin
      period_valid <= cap_fire;
      if (cap_fire) begin
        period_out <= tmr_q;
        tmr_ovf    <= 1'b0;
      end else if (tmr_q == TMR_MAX) begin
        tmr_ovf    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qvc_period_capture_chk.sv
module qvc_period_capture_chk #(
  parameter int TMR_W = 16,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             vel_disable,
  input logic [TMR_W-1:0] period_out,
  input logic             period_valid,
  input logic             tmr_ovf,
  input logic [TMR_W-1:0] tmr_q,
  input logic             cap_fire,
  input logic             evt_q,
  input logic [CNT_W-1:0] div_cnt,
  input logic [CNT_W-1:0] div_lim
);
  AST_NO_EVT_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(vel_disable) |-> !evt_q);                                   // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= div_lim);                                              // R5
  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (rst)
    period_valid |-> (tmr_q == '0));                                  // R7
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> period_valid);                                       // R8
  AST_VALID_ONLY_ON_CAP: assert property (@(posedge clk) disable iff (rst)
    !cap_fire |=> !period_valid);                                     // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (tmr_q == '1 && !cap_fire) |=> tmr_ovf);                          // R9
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    period_valid |-> !tmr_ovf);                                       // R9
  AST_SAT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (period_valid && $past(tmr_ovf)) |-> (period_out == '1));         // R9
endmodule

bind qvc_period_capture qvc_period_capture_chk #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .vel_disable  (vel_disable),
  .period_out   (period_out),
  .period_valid (period_valid),
  .tmr_ovf      (tmr_ovf),
  .tmr_q        (tmr_q),
  .cap_fire     (cap_fire),
  .evt_q        (evt_q),
  .div_cnt      (div_cnt),
  .div_lim      (div_lim)
);

// File: tb/qvc_period_capture_bench.sv
module qvc_period_capture_bench;
  localparam int TMR_W = 16;
  localparam int TMAX  = (1 << TMR_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             phase_a = 1'b0;
  logic             phase_b = 1'b0;
  logic             vel_disable = 1'b0;
  logic [2:0]       qmode = 3'b000;
  logic [1:0]       post_sel = 2'd0;
  logic [TMR_W-1:0] period_out;
  logic             period_valid;
  logic             tmr_ovf;

  always #2 clk = ~clk;

  qvc_period_capture u_qvc_period_capture (
    .clk          (clk),
    .rst          (rst),
    .phase_a      (phase_a),
    .phase_b      (phase_b),
    .vel_disable  (vel_disable),
    .qmode        (qmode),
    .post_sel     (post_sel),
    .period_out   (period_out),
    .period_valid (period_valid),
    .tmr_ovf      (tmr_ovf)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic             skip;
    logic [TMR_W-1:0] val;
  } exp_t;
  exp_t expq[$];

  int  n_cmp = 0;
  int  n_bad = 0;
  int  mode_m = 0;      // 0 off, 1 two-times, 2 four-times
  int  ratio_m = 1;
  int  ev_cnt = 0;
  bit  have_last = 1'b0;
  int  last_stim = 0;
  bit  done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Requirement model: count events, push the expected period on a completed group
  function automatic void model_event();
    int gap;
    exp_t e;
    if (mode_m == 0) return;
    ev_cnt++;
    if (ev_cnt == ratio_m) begin
      ev_cnt = 0;
      gap    = cyc - last_stim;
      e.skip = !have_last;
      e.val  = (gap - 1 > TMAX) ? TMR_W'(TMAX) : TMR_W'(gap - 1);
      expq.push_back(e);
      have_last = 1'b1;
      last_stim = cyc;
    end
  endfunction

  task automatic set_cfg(input logic dis, input logic [2:0] m, input logic [1:0] ps);
    repeat (6) @(negedge clk);
    vel_disable = dis;
    qmode       = m;
    post_sel    = ps;
    if (dis) mode_m = 0;
    else if (m == 3'b001 || m == 3'b010) mode_m = 1;
    else if (m == 3'b101 || m == 3'b110) mode_m = 2;
    else mode_m = 0;
    ratio_m = 1 << (2 * ps);
    ev_cnt  = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic toggle(input bit ta, input bit tb, input int gap);
    @(negedge clk);
    if (ta) phase_a = ~phase_a;
    if (tb) phase_b = ~phase_b;
    if ((mode_m == 1 && ta) || (mode_m == 2 && (ta || tb))) model_event();
    repeat (gap - 1) @(negedge clk);
  endtask

  // Monitor: pops one expected item for every capture strobe
  always @(negedge clk) begin
    exp_t e;
    if (!rst && period_valid) begin
      if (expq.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R4/R5/R6: actual unexpected capture %0d expected none", period_out);
      end else begin
        e = expq.pop_front();
        if (!e.skip) check("R7 period value", int'(period_out), int'(e.val));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (4) @(negedge clk);
    check("R1 valid in reset", int'(period_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 period after reset", int'(period_out), 0);
    check("R1 valid after reset", int'(period_valid), 0);
    check("R1 ovf after reset", int'(tmr_ovf), 0);

    // R2: two-times decoding, phase B ignored
    set_cfg(1'b0, 3'b001, 2'd0);
    toggle(1, 0, 10); toggle(1, 0, 10); toggle(0, 1, 10);
    toggle(1, 0, 15); toggle(0, 1, 6);  toggle(1, 0, 7);
    set_cfg(1'b0, 3'b010, 2'd0);
    toggle(1, 0, 9);  toggle(0, 1, 5);  toggle(1, 0, 13);

    // R8: latency and single-cycle strobe
    repeat (6) @(negedge clk);
    phase_a = ~phase_a;
    model_event();
    s = cyc;
    @(negedge clk);
    while (!period_valid) @(negedge clk);
    check("R8 capture latency", cyc - s, 4);
    @(negedge clk);
    check("R8 strobe width", int'(period_valid), 0);

    // R3: four-times decoding, coincident edges counted once
    set_cfg(1'b0, 3'b101, 2'd0);
    toggle(1, 0, 8); toggle(0, 1, 12); toggle(1, 0, 5);
    toggle(0, 1, 9); toggle(1, 1, 11); toggle(1, 0, 6);
    toggle(1, 1, 7); toggle(0, 1, 4);

    // R5: postscaler ratios 4, 16, 64
    set_cfg(1'b0, 3'b110, 2'd1);
    for (int i = 0; i < 12; i++) toggle(i[0], !i[0], 3 + i);
    set_cfg(1'b0, 3'b001, 2'd2);
    for (int i = 0; i < 32; i++) toggle(1, 0, 2 + (i % 3));
    set_cfg(1'b0, 3'b110, 2'd3);
    for (int i = 0; i < 128; i++) toggle(i[0], !i[0], 2);

    // R4: disabled and non-operating codes give no captures
    set_cfg(1'b1, 3'b001, 2'd0);
    for (int i = 0; i < 4; i++) toggle(1, 1, 5);
    for (int k = 0; k < 4; k++) begin
      set_cfg(1'b0, (k == 0) ? 3'b000 : (k == 1) ? 3'b011 : (k == 2) ? 3'b100 : 3'b111, 2'd0);
      for (int i = 0; i < 3; i++) toggle(1, 1, 5);
    end

    // R6: configuration change clears the partial count
    set_cfg(1'b0, 3'b001, 2'd1);
    toggle(1, 0, 5); toggle(1, 0, 5);
    set_cfg(1'b0, 3'b001, 2'd2);
    set_cfg(1'b0, 3'b001, 2'd1);
    for (int i = 0; i < 4; i++) toggle(1, 0, 6);

    // R9: saturation and sticky overflow
    set_cfg(1'b0, 3'b001, 2'd0);
    toggle(1, 0, 1000);
    check("R9 ovf clear before limit", int'(tmr_ovf), 0);
    repeat (69000) @(negedge clk);
    check("R9 ovf set after limit", int'(tmr_ovf), 1);
    toggle(1, 0, 10);
    check("R9 ovf cleared by capture", int'(tmr_ovf), 0);

    repeat (20) @(negedge clk);
    check("R8 every expected capture seen", expq.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule